// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a bus-mapped periodic timer. The system clock passes through a fixed divide-by-16 prescaler. Each prescaled tick advances a 20-bit interval counter. When the counter reaches a programmed limit it returns to zero, and that completes one period. Each completed period sets a sticky status flag and increments a 12-bit elapsed-period tally. The interrupt output is the status flag qualified by an interrupt-enable bit.

Software sees four word registers on a simple synchronous bus:

| Offset | Register | Purpose |
|--------|----------|---------|
| 0x0 | control | interval limit and enable bits |
| 0x4 | flag | sticky status flag |
| 0x8 | acknowledging snapshot | returns the tally and the live count, then acknowledges |
| 0xC | passive snapshot | returns the same fields with no side effect |

The acknowledging snapshot suits an interrupt handler. The passive snapshot suits a free-running time base.

Clearing the enable bit does not stop the timer at once. The current period runs to completion, and the counter then rests at zero. A limit written while the timer runs is held back until the next wrap.

Top module: `ptmr_top`

## Requirements
- R1: While running, the interval counter advances by one on every 16th clock cycle: the first increment lands on the 16th rising edge after the edge that writes the enable bit.
- R2: A period lasts limit+1 prescaled ticks. When a tick finds the counter equal to the limit, the counter becomes 0 and the tally increments.
- R3: Control register at offset 0x0: bits [19:0] hold the limit, bit 24 enables counting and bit 25 enables the interrupt. Reads return these fields, with all other bits zero.
- R4: Flag register at offset 0x4: bit 0 becomes 1 on each wrap and stays 1 until an acknowledge.
- R5: Reading offset 0x8 returns the tally in bits [31:20] and the live count in bits [19:0]. The clock edge that ends the read clears the tally to 0 and clears the flag.
- R6: When a wrap and an acknowledging read share a clock edge, the tally ends at 1 and the flag ends at 1.
- R7: Reading offset 0xC returns the same fields as offset 0x8 and changes neither the tally nor the flag.
- R8: Without acknowledges, the tally saturates at 4095 instead of wrapping.
- R9: After the enable bit is cleared, the counter keeps counting until its next wrap, then holds at 0 with the prescaler stopped.
- R10: A new limit written while the timer is running takes effect only at the next wrap. A limit written while the timer is idle applies to the period that the same write starts.
- R11: irq_o is high exactly while the flag is 1 and the interrupt-enable bit is 1. It is a level, not a pulse.
- R12: After reset, every register, the counter, the tally, the flag and irq_o read as zero.
- R13: Reads of any address with bits [1:0] non-zero, or of the flag register for any bit other than bit 0, return zeros. Writes to any address other than 0x0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe; read data is valid in the same cycle |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; zero when no mapped read is active |
| irq_o | output | 1 | Level interrupt request |

## Verification
The acknowledge caused by an offset-0x8 read can land on the same clock edge as a counter wrap. That edge both clears and increments the tally, and it both clears and sets the flag.

The bench provokes this collision with a limit of zero, so that a wrap falls on every 16th edge. It places the acknowledging read so that the edge ending the read is exactly the 32nd edge after enable. The read must return a tally of 1, which comes from the earlier wrap. A following passive read must then show a tally of 1 and the flag still set: the new period is counted after the clear, not lost to it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int CNT_W   = 20;
  localparam int OVF_W   = 12;
  localparam int PRESC_W = 4;
  localparam int EN_POS  = 24;
  localparam int IEN_POS = 25;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_FLAG  = 2'd1,
    SEL_SNAP  = 2'd2,
    SEL_PEEK  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  logic [W-1:0] div_q, div_d;

  always_comb begin
    div_d  = div_q;
    tick_o = 1'b0;
    if (run_i) begin
      div_d  = div_q + 1'b1;
      tick_o = (div_q == {W{1'b1}});
    end else begin
      div_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ptmr_core.sv
module ptmr_core #(
  parameter int CNT_W = 20,
  parameter int OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_reg_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_lim_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OVF_W-1:0] ovf_o,
  output logic             flag_o,
  output logic             run_o
);
  localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             flag_q, flag_d;
  logic             wrap;

  assign run_o = en_i | (cnt_q != '0);
  assign wrap  = tick_i && (cnt_q == lim_q);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = wrap ? '0 : cnt_q + 1'b1;

    lim_d = lim_q;
    if (!run_o) lim_d = ld_i ? ld_lim_i : lim_reg_i;
    else if (wrap) lim_d = lim_reg_i;

    ovf_d = ovf_q;
    if (ack_i && wrap)        ovf_d = {{(OVF_W-1){1'b0}}, 1'b1};
    else if (ack_i)           ovf_d = '0;
    else if (wrap && ovf_q != OVF_MAX) ovf_d = ovf_q + 1'b1;

    flag_d = flag_q;
    if (wrap)       flag_d = 1'b1;
    else if (ack_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      ovf_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      ovf_q  <= ovf_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign flag_o = flag_q;

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == lim_q) |=> (cnt_q == '0) && flag_q);
  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack_i) |=> flag_q);
  // R6
  ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && tick_i && cnt_q == lim_q) |=> (ovf_q == 1) && flag_q);
  // R8
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q == OVF_MAX && !ack_i) |=> (ovf_q == OVF_MAX));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int OVF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [OVF_W-1:0]  ovf_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              en_o,
  output logic              ien_o,
  output logic              ld_o,
  output logic [CNT_W-1:0]  ld_lim_o,
  output logic              ack_o
);
  logic             mapped;
  reg_sel_e         sel;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             en_q, en_d, ien_q, ien_d;
  logic             unused_wbits;

  assign mapped   = (addr_i[1:0] == 2'b00);
  assign sel      = reg_sel_e'(addr_i[3:2]);
  assign ld_o     = wr_en_i && mapped && (sel == SEL_CTRL);
  assign ld_lim_o = wdata_i[CNT_W-1:0];
  assign ack_o    = rd_en_i && mapped && (sel == SEL_SNAP);
  assign unused_wbits = ^{wdata_i[DATA_W-1:IEN_POS+1], wdata_i[EN_POS-1:CNT_W]};

  always_comb begin
    lim_d = lim_q;
    en_d  = en_q;
    ien_d = ien_q;
    if (ld_o) begin
      lim_d = wdata_i[CNT_W-1:0];
      en_d  = wdata_i[EN_POS];
      ien_d = wdata_i[IEN_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      en_q  <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      lim_q <= lim_d;
      en_q  <= en_d;
      ien_q <= ien_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && mapped) begin
      unique case (sel)
        SEL_CTRL: begin
          rdata_o[CNT_W-1:0] = lim_q;
          rdata_o[EN_POS]    = en_q;
          rdata_o[IEN_POS]   = ien_q;
        end
        SEL_FLAG: rdata_o[0] = flag_i;
        SEL_SNAP, SEL_PEEK: begin
          rdata_o[CNT_W-1:0]     = cnt_i;
          rdata_o[CNT_W +: OVF_W] = ovf_i;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign lim_o = lim_q;
  assign en_o  = en_q;
  assign ien_o = ien_q;

  // R13
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !(mapped && sel == SEL_CTRL)) |=> $stable({lim_q, en_q, ien_q}));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] lim, ld_lim, cnt;
  logic [OVF_W-1:0] ovf;
  logic             en, ien, ld, ack, flag, run, tick;

  ptmr_regs #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt), .ovf_i(ovf),
    .flag_i(flag), .rdata_o(rdata_o), .lim_o(lim), .en_o(en),
    .ien_o(ien), .ld_o(ld), .ld_lim_o(ld_lim), .ack_o(ack)
  );

  ptmr_prescale #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(tick)
  );

  ptmr_core #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .lim_reg_i(lim),
    .ld_i(ld), .ld_lim_i(ld_lim), .ack_i(ack), .cnt_o(cnt), .ovf_o(ovf),
    .flag_o(flag), .run_o(run)
  );

  assign irq_o = flag & ien;

  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ien && !ack && !ld) |=> irq_o);
  // R1
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
endmodule

// File: tb/ptmr_top_tb_top.sv
`timescale 1ns/1ps
module ptmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata, rv;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [31:0] EN  = 32'h0100_0000;
  localparam logic [31:0] IEN = 32'h0200_0000;
  // limit, edges after enable write, expected count, expected tally
  localparam int VEC [6][4] = '{
    '{3, 40, 2, 0}, '{3, 64, 0, 1}, '{0, 80, 0, 5},
    '{4, 170, 0, 2}, '{2, 100, 0, 2}, '{1, 50, 1, 1}
  };

  always #10 clk = ~clk;

  ptmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    #2 d = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(a[3:0], rv); chk("R12 reset read", rv, 32'h0);
    end
    chk("R12 reset irq", {31'b0, irq}, 32'h0);

    // R1 R2 vector table
    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(4'h0, EN | VEC[i][0]);
      repeat (VEC[i][1]) @(posedge clk);
      rd(4'hC, rv);
      chk("R1/R2 vector", rv, (32'(VEC[i][3]) << 20) | 32'(VEC[i][2]));
    end

    // R3 R4 R5 R11
    do_reset();
    wr(4'h0, EN | IEN | 32'd9);
    repeat (159) @(posedge clk);
    @(negedge clk) chk("R11 irq before wrap", {31'b0, irq}, 0);
    @(posedge clk);
    @(negedge clk) chk("R11 irq after wrap", {31'b0, irq}, 1);
    rd(4'h4, rv); chk("R4 flag set", rv, 1);
    rd(4'h0, rv); chk("R3 control readback", rv, EN | IEN | 32'd9);
    wr(4'h0, EN | 32'd9);
    @(negedge clk) chk("R11 irq masked", {31'b0, irq}, 0);
    rd(4'h4, rv); chk("R4 flag sticky", rv, 1);
    rd(4'h8, rv); chk("R5 value read", rv, 32'h0010_0000);
    rd(4'h4, rv); chk("R5 flag cleared", rv, 0);
    rd(4'hC, rv); chk("R5 tally cleared", rv, 0);

    // R6 R7 same-edge wrap and acknowledge
    do_reset();
    wr(4'h0, EN);
    repeat (31) @(posedge clk);
    rd(4'h8, rv); chk("R6 read at collision", rv, 32'h0010_0000);
    rd(4'hC, rv); chk("R6 tally after collision", rv, 32'h0010_0000);
    rd(4'hC, rv); chk("R7 peek no side effect", rv, 32'h0010_0000);
    rd(4'h4, rv); chk("R6 flag after collision", rv, 1);

    // R9 disable finishes period
    do_reset();
    wr(4'h0, EN | 32'd3);
    repeat (32) @(posedge clk);
    wr(4'h0, 32'd3);
    repeat (16) @(posedge clk);
    rd(4'hC, rv); chk("R9 still running", rv, 32'd3);
    repeat (40) @(posedge clk);
    rd(4'hC, rv); chk("R9 stopped at zero", rv, 32'h0010_0000);

    // R10 limit change deferred to wrap
    do_reset();
    wr(4'h0, EN | 32'd3);
    repeat (16) @(posedge clk);
    wr(4'h0, EN | 32'd1);
    repeat (46) @(posedge clk);
    rd(4'hC, rv); chk("R10 old limit holds", rv, 32'd3);
    repeat (35) @(posedge clk);
    rd(4'hC, rv); chk("R10 new limit after wrap", rv, 32'h0020_0000);

    // R13 unmapped access
    do_reset();
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, rv); chk("R13 writes ignored", rv, 0);
    repeat (40) @(posedge clk);
    rd(4'hC, rv); chk("R13 timer idle", rv, 0);
    wr(4'h0, EN | IEN | 32'd5);
    rd(4'h2, rv); chk("R13 unmapped read", rv, 0);
    rd(4'h1, rv); chk("R13 unmapped read odd", rv, 0);

    // R8 saturation
    do_reset();
    wr(4'h0, EN);
    repeat (16 * 4100) @(posedge clk);
    rd(4'hC, rv); chk("R8 saturated peek", rv, 32'hFFF0_0000);
    rd(4'h8, rv); chk("R8 saturated ack", rv, 32'hFFF0_0000);
    rd(4'hC, rv); chk("R8 cleared", rv, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule